// File: doc/BRIEF.md
# Single-Line Coherence Directory Controller

This block serialises coherence traffic for one cache line at a time. Cores send it shared reads, plain reads, reads for ownership, change-to-dirty upgrades, write-throughs, atomics and clean or dirty evictions. For a read-type request it starts a memory fetch and a probe broadcast to the other cores in the same cycle. It then tracks the probe acknowledgements and the fill separately, so the fill may come before, between or after the acknowledgements. The fill can come from memory or from a last-level-cache hit.

Once both halves are done, the controller picks the grant from the request class and from whether any probed core still held the line. The line then stays busy until the requester unblocks it. Write-throughs and atomics instead release the line through an internal one-cycle trigger. Evictions take a short path: they are acknowledged at once, and the victim data is then forwarded to memory.

Each input channel is a valid/ready pair. A fixed-priority arbiter serves one input per cycle. The outputs are registered single-cycle pulses.

Top module: `dir_line_ctrl`

## Requirements
- R1: After reset the line is unblocked, every output pulse is low, `err_o` is 0, and `req_ready` is high only while `req_valid` is high.
- R2: An accepted request starts work in the next cycle. Kind 0 (shared read) and kind 1 (plain read) give one `memrd_o` pulse and a probe of kind 1 (downgrade). Kinds 2 (read-modify), 4 (write-through) and 5 (atomic) give one `memrd_o` pulse and a probe of kind 2 (invalidate, return data). Kind 3 (change-to-dirty) gives a probe of kind 3 (invalidate, no data) and no memory read.
- R3: An accepted write-through gets a grant of kind 4 (write acknowledge) to its source in the next cycle, before any probe or memory completion.
- R4: While the line is busy, no request is accepted (`req_ready` stays low).
- R5: A read-type transaction grants only after all NUM_CORES-1 probe acknowledgements (`rsp_kind` 0) have arrived and the fill has arrived (`mem_kind` 0, or an `llc_valid` hit), in any order. A change-to-dirty needs only the acknowledgements.
- R6: Grant kinds are 0 Shared, 1 Exclusive and 2 Modified. A shared read gets 0. A plain read gets 0 if any acknowledgement had `rsp_hit` set or the request had `req_fshr` set, and 1 otherwise. A read-modify or atomic gets 2. `grant_dst_o` is the requester.
- R7: A change-to-dirty completes with a grant of kind 3, a dataless ownership acknowledgement.
- R8: A write-through sends no final grant and an atomic sends its kind-2 grant. Both return the line to unblocked without a core unblock.
- R9: An eviction (kinds 6 and 7) is acknowledged with grant kind 4. Victim data (`rsp_kind` 1) then produces one `memwr_o` pulse carrying that data. A stale notice (`rsp_kind` 2) writes nothing. Either one frees the line.
- R10: A memory write acknowledgement (`mem_kind` 1) is accepted in every state and has no effect.
- R11: Inputs are served one per cycle in this order: internal trigger, LLC hit, unblock, core response, memory, request.
- R12: A message that is illegal in the current state sets the sticky `err_o` and changes no state.
- R13: After a grant of kind 0, 1 or 2 that is not an atomic's, the line stays busy until a core unblock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted |
| req_kind | input | 3 | Request kind (see R2, R9) |
| req_src | input | SRC_W | Requesting core |
| req_fshr | input | 1 | Requester forces a Shared grant |
| rsp_valid | input | 1 | Core response valid |
| rsp_ready | output | 1 | Core response accepted |
| rsp_kind | input | 2 | 0 probe ack, 1 victim data, 2 stale notice |
| rsp_hit | input | 1 | Probed core held the line |
| rsp_data | input | DATA_W | Victim data |
| unb_valid | input | 1 | Core unblock valid |
| unb_ready | output | 1 | Core unblock accepted |
| mem_valid | input | 1 | Memory response valid |
| mem_ready | output | 1 | Memory response accepted |
| mem_kind | input | 1 | 0 read data, 1 write acknowledge |
| llc_valid | input | 1 | Last-level-cache hit valid |
| llc_ready | output | 1 | LLC hit accepted |
| memrd_o | output | 1 | Memory read launch pulse |
| prb_valid_o | output | 1 | Probe broadcast pulse |
| prb_kind_o | output | 2 | 1 downgrade, 2 invalidate with data, 3 invalidate no data |
| grant_valid_o | output | 1 | Grant pulse |
| grant_kind_o | output | 3 | Grant kind (R6, R7, R3) |
| grant_dst_o | output | SRC_W | Grant destination core |
| memwr_o | output | 1 | Memory write pulse |
| memwr_data_o | output | DATA_W | Memory write data |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with NUM_CORES=4, SRC_W=2 and DATA_W=16, so every read-type transaction waits for three probe acknowledgements. With three acknowledgements the fill can arrive before all of them, between the first and second, or after the last, which covers every path through the split states. The 16-bit data width lets each victim write carry a distinct random value, so a write with the wrong data is caught.

// File: rtl/dir_line_pkg.sv
package dir_line_pkg;

  // Input slots, in service order: a lower index is served first.
  localparam int SRC_TRG = 0;
  localparam int SRC_LLC = 1;
  localparam int SRC_UNB = 2;
  localparam int SRC_RSP = 3;
  localparam int SRC_MEM = 4;
  localparam int SRC_REQ = 5;
  localparam int NUM_SRC = 6;

  typedef enum logic [2:0] {
    RQ_RDS  = 3'd0, RQ_RD   = 3'd1, RQ_RDM  = 3'd2, RQ_CTOD = 3'd3,
    RQ_WT   = 3'd4, RQ_ATOM = 3'd5, RQ_VICD = 3'd6, RQ_VICC = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    CR_PACK = 2'd0, CR_VDATA = 2'd1, CR_STALE = 2'd2, CR_BAD = 2'd3
  } core_rsp_e;

  typedef enum logic [2:0] {
    GR_SHR = 3'd0, GR_EXC = 3'd1, GR_MOD = 3'd2, GR_CTOD = 3'd3, GR_WBACK = 3'd4
  } grant_e;

  typedef enum logic [1:0] {
    PB_NONE = 2'd0, PB_DOWN = 2'd1, PB_INVD = 2'd2, PB_INVN = 2'd3
  } probe_e;

  typedef enum logic [1:0] { CL_SHR = 2'd0, CL_PLN = 2'd1, CL_MOD = 2'd2 } cls_e;

  // BOTH: probes and fill outstanding; PRB: only probes; MEM: only fill.
  typedef enum logic [1:0] { PH_BOTH = 2'd0, PH_PRB = 2'd1, PH_MEM = 2'd2 } phase_e;

  typedef enum logic [3:0] {
    ST_UNBLK, ST_WBWAIT,
    ST_S_BOTH, ST_S_PRB, ST_S_MEM,
    ST_P_BOTH, ST_P_PRB, ST_P_MEM,
    ST_M_BOTH, ST_M_PRB, ST_M_MEM,
    ST_CTOD, ST_WAITUNB
  } line_st_e;

  typedef enum logic [1:0] { TG_NONE = 2'd0, TG_ACKS = 2'd1, TG_WTUNB = 2'd2 } trig_e;

  function automatic line_st_e compose(cls_e c, phase_e p);
    case ({c, p})
      {CL_SHR, PH_BOTH}: return ST_S_BOTH;
      {CL_SHR, PH_PRB}:  return ST_S_PRB;
      {CL_SHR, PH_MEM}:  return ST_S_MEM;
      {CL_PLN, PH_BOTH}: return ST_P_BOTH;
      {CL_PLN, PH_PRB}:  return ST_P_PRB;
      {CL_PLN, PH_MEM}:  return ST_P_MEM;
      {CL_MOD, PH_BOTH}: return ST_M_BOTH;
      {CL_MOD, PH_PRB}:  return ST_M_PRB;
      {CL_MOD, PH_MEM}:  return ST_M_MEM;
      default:           return ST_UNBLK;
    endcase
  endfunction

  function automatic logic is_split(line_st_e s);
    case (s)
      ST_S_BOTH, ST_S_PRB, ST_S_MEM,
      ST_P_BOTH, ST_P_PRB, ST_P_MEM,
      ST_M_BOTH, ST_M_PRB, ST_M_MEM: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction

  function automatic phase_e phase_of(line_st_e s);
    case (s)
      ST_S_BOTH, ST_P_BOTH, ST_M_BOTH: return PH_BOTH;
      ST_S_PRB, ST_P_PRB, ST_M_PRB:    return PH_PRB;
      default:                         return PH_MEM;
    endcase
  endfunction

endpackage

// File: rtl/dir_prio_arb.sv
module dir_prio_arb #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign gnt_o[i] = req_i[i] & ~seen[i];
    if (i + 1 < N) begin : g_next
      assign seen[i+1] = seen[i] | req_i[i];
    end
  end
endmodule

// File: rtl/dir_ack_track.sv
module dir_ack_track #(
  parameter int NPEER = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic dec_i,
  input  logic hit_i,
  output logic last_o,
  output logic hit_o
);
  localparam int CW = (NPEER < 1) ? 1 : $clog2(NPEER + 1);
  localparam logic [CW-1:0] LOADV = CW'(NPEER);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit_o <= 1'b0;
    end else if (load_i) begin
      cnt_q <= LOADV;
      hit_o <= 1'b0;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CW'(1);
      hit_o <= hit_o | hit_i;
    end
  end

  assign last_o = (load_i && (NPEER == 0)) || (dec_i && (cnt_q == CW'(1)));

  // An acknowledgement is only taken while some are still outstanding.
  assert_ack_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/dir_line_fsm.sv
module dir_line_fsm
  import dir_line_pkg::*;
#(
  parameter int SRC_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] gnt_i,
  input  logic [2:0]         req_kind_i,
  input  logic [SRC_W-1:0]   req_src_i,
  input  logic               req_fshr_i,
  input  logic [1:0]         rsp_kind_i,
  input  logic [DATA_W-1:0]  rsp_data_i,
  input  logic               mem_kind_i,
  input  logic               ack_last_i,
  input  logic               ack_hit_i,
  output logic               req_ok_o,
  output logic               trig_pend_o,
  output logic               ack_load_o,
  output logic               ack_dec_o,
  output logic               memrd_o,
  output logic               prb_valid_o,
  output logic [1:0]         prb_kind_o,
  output logic               grant_valid_o,
  output logic [2:0]         grant_kind_o,
  output logic [SRC_W-1:0]   grant_dst_o,
  output logic               memwr_o,
  output logic [DATA_W-1:0]  memwr_data_o,
  output logic               err_o
);
  line_st_e        st_q;
  cls_e            cls_q;
  trig_e           trig_q;
  logic            wt_q, atom_q, fshr_q;
  logic [SRC_W-1:0] dst_q;

  req_kind_e rk;
  core_rsp_e ck;
  phase_e    ph;
  logic      sp, prb_live, mem_fill, finish, illegal;
  grant_e    fin_kind;
  logic      fin_send, fin_wtunb;

  assign rk          = req_kind_e'(req_kind_i);
  assign ck          = core_rsp_e'(rsp_kind_i);
  assign ph          = phase_of(st_q);
  assign sp          = is_split(st_q);
  assign req_ok_o    = (st_q == ST_UNBLK);
  assign trig_pend_o = (trig_q != TG_NONE);
  assign prb_live    = (sp && ph != PH_MEM) || (st_q == ST_CTOD);
  assign mem_fill    = gnt_i[SRC_LLC] || (gnt_i[SRC_MEM] && !mem_kind_i);
  assign ack_dec_o   = gnt_i[SRC_RSP] && (ck == CR_PACK) && prb_live;
  assign ack_load_o  = gnt_i[SRC_REQ] && (rk != RQ_VICD) && (rk != RQ_VICC);

  assign finish = (gnt_i[SRC_TRG] && trig_q == TG_ACKS &&
                   ((st_q == ST_CTOD) || (sp && ph == PH_PRB))) ||
                  (mem_fill && sp && ph == PH_MEM);

  assign illegal = (mem_fill && !(sp && ph != PH_PRB)) ||
                   (gnt_i[SRC_UNB] && st_q != ST_WAITUNB) ||
                   (gnt_i[SRC_RSP] && ((ck == CR_PACK && !prb_live) ||
                                       ((ck == CR_VDATA || ck == CR_STALE) && st_q != ST_WBWAIT) ||
                                       (ck == CR_BAD)));

  // Grant chosen at completion, from the class and the probe outcome.
  always_comb begin
    fin_send  = 1'b1;
    fin_wtunb = 1'b0;
    fin_kind  = GR_MOD;
    if (st_q == ST_CTOD) begin
      fin_kind = GR_CTOD;
    end else begin
      case (cls_q)
        CL_SHR:  fin_kind = GR_SHR;
        CL_PLN:  fin_kind = (ack_hit_i || fshr_q) ? GR_SHR : GR_EXC;
        default: begin
          fin_kind = GR_MOD;
          if (wt_q) begin
            fin_send  = 1'b0;
            fin_wtunb = 1'b1;
          end else if (atom_q) begin
            fin_wtunb = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_UNBLK;
      cls_q         <= CL_SHR;
      trig_q        <= TG_NONE;
      wt_q          <= 1'b0;
      atom_q        <= 1'b0;
      fshr_q        <= 1'b0;
      dst_q         <= '0;
      memrd_o       <= 1'b0;
      prb_valid_o   <= 1'b0;
      prb_kind_o    <= PB_NONE;
      grant_valid_o <= 1'b0;
      grant_kind_o  <= GR_SHR;
      grant_dst_o   <= '0;
      memwr_o       <= 1'b0;
      memwr_data_o  <= '0;
      err_o         <= 1'b0;
    end else begin
      memrd_o       <= 1'b0;
      prb_valid_o   <= 1'b0;
      grant_valid_o <= 1'b0;
      memwr_o       <= 1'b0;
      err_o         <= err_o | illegal;
      if (gnt_i[SRC_TRG]) trig_q <= TG_NONE;
      if (ack_last_i)     trig_q <= TG_ACKS;

      if (finish) begin
        st_q          <= ST_WAITUNB;
        grant_valid_o <= fin_send;
        grant_kind_o  <= fin_kind;
        grant_dst_o   <= dst_q;
        if (fin_wtunb) trig_q <= TG_WTUNB;
      end else if (gnt_i[SRC_TRG]) begin
        if (trig_q == TG_ACKS && sp && ph == PH_BOTH)
          st_q <= compose(cls_q, PH_MEM);
        else if (trig_q == TG_WTUNB && st_q == ST_WAITUNB)
          st_q <= ST_UNBLK;
      end else if (mem_fill) begin
        if (sp && ph == PH_BOTH) st_q <= compose(cls_q, PH_PRB);
      end else if (gnt_i[SRC_UNB]) begin
        if (st_q == ST_WAITUNB) st_q <= ST_UNBLK;
      end else if (gnt_i[SRC_RSP]) begin
        if (st_q == ST_WBWAIT && ck == CR_VDATA) begin
          memwr_o      <= 1'b1;
          memwr_data_o <= rsp_data_i;
          st_q         <= ST_UNBLK;
        end else if (st_q == ST_WBWAIT && ck == CR_STALE) begin
          st_q <= ST_UNBLK;
        end
      end else if (gnt_i[SRC_REQ]) begin
        dst_q  <= req_src_i;
        fshr_q <= req_fshr_i;
        wt_q   <= (rk == RQ_WT);
        atom_q <= (rk == RQ_ATOM);
        case (rk)
          RQ_RDS, RQ_RD: begin
            cls_q       <= (rk == RQ_RDS) ? CL_SHR : CL_PLN;
            st_q        <= (rk == RQ_RDS) ? ST_S_BOTH : ST_P_BOTH;
            memrd_o     <= 1'b1;
            prb_valid_o <= 1'b1;
            prb_kind_o  <= PB_DOWN;
          end
          RQ_RDM, RQ_WT, RQ_ATOM: begin
            cls_q       <= CL_MOD;
            st_q        <= ST_M_BOTH;
            memrd_o     <= 1'b1;
            prb_valid_o <= 1'b1;
            prb_kind_o  <= PB_INVD;
            if (rk == RQ_WT) begin
              grant_valid_o <= 1'b1;
              grant_kind_o  <= GR_WBACK;
              grant_dst_o   <= req_src_i;
            end
          end
          RQ_CTOD: begin
            st_q        <= ST_CTOD;
            prb_valid_o <= 1'b1;
            prb_kind_o  <= PB_INVN;
          end
          default: begin
            st_q          <= ST_WBWAIT;
            grant_valid_o <= 1'b1;
            grant_kind_o  <= GR_WBACK;
            grant_dst_o   <= req_src_i;
          end
        endcase
      end
    end
  end

  assert_wt_early_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt_i[SRC_REQ] && rk == RQ_WT) |=> (grant_valid_o && grant_kind_o == GR_WBACK));

  assert_read_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt_i[SRC_REQ] && (rk == RQ_RDS || rk == RQ_RD)) |=>
      (memrd_o && prb_valid_o && prb_kind_o == PB_DOWN));

  assert_ctod_no_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt_i[SRC_REQ] && rk == RQ_CTOD) |=> (!memrd_o && prb_valid_o && prb_kind_o == PB_INVN));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  assert_busy_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_UNBLK) |-> !gnt_i[SRC_REQ]);
endmodule

// File: rtl/dir_line_ctrl.sv
module dir_line_ctrl
  import dir_line_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SRC_W     = 2,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [SRC_W-1:0]  req_src,
  input  logic              req_fshr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_kind,
  input  logic              rsp_hit,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              unb_valid,
  output logic              unb_ready,
  input  logic              mem_valid,
  output logic              mem_ready,
  input  logic              mem_kind,
  input  logic              llc_valid,
  output logic              llc_ready,
  output logic              memrd_o,
  output logic              prb_valid_o,
  output logic [1:0]        prb_kind_o,
  output logic              grant_valid_o,
  output logic [2:0]        grant_kind_o,
  output logic [SRC_W-1:0]  grant_dst_o,
  output logic              memwr_o,
  output logic [DATA_W-1:0] memwr_data_o,
  output logic              err_o
);
  localparam int NPEER = NUM_CORES - 1;

  logic [NUM_SRC-1:0] want, gnt;
  logic req_ok, trig_pend, ack_load, ack_dec, ack_last, ack_hit;

  always_comb begin
    want          = '0;
    want[SRC_TRG] = trig_pend;
    want[SRC_LLC] = llc_valid;
    want[SRC_UNB] = unb_valid;
    want[SRC_RSP] = rsp_valid;
    want[SRC_MEM] = mem_valid;
    want[SRC_REQ] = req_valid && req_ok;
  end

  dir_prio_arb #(.N(NUM_SRC)) u_arb (.req_i(want), .gnt_o(gnt));

  assign llc_ready = gnt[SRC_LLC];
  assign unb_ready = gnt[SRC_UNB];
  assign rsp_ready = gnt[SRC_RSP];
  assign mem_ready = gnt[SRC_MEM];
  assign req_ready = gnt[SRC_REQ];

  dir_ack_track #(.NPEER(NPEER)) u_acks (
    .clk(clk), .rst(rst), .load_i(ack_load), .dec_i(ack_dec), .hit_i(rsp_hit),
    .last_o(ack_last), .hit_o(ack_hit)
  );

  dir_line_fsm #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .gnt_i(gnt),
    .req_kind_i(req_kind), .req_src_i(req_src), .req_fshr_i(req_fshr),
    .rsp_kind_i(rsp_kind), .rsp_data_i(rsp_data), .mem_kind_i(mem_kind),
    .ack_last_i(ack_last), .ack_hit_i(ack_hit),
    .req_ok_o(req_ok), .trig_pend_o(trig_pend), .ack_load_o(ack_load), .ack_dec_o(ack_dec),
    .memrd_o(memrd_o), .prb_valid_o(prb_valid_o), .prb_kind_o(prb_kind_o),
    .grant_valid_o(grant_valid_o), .grant_kind_o(grant_kind_o), .grant_dst_o(grant_dst_o),
    .memwr_o(memwr_o), .memwr_data_o(memwr_data_o), .err_o(err_o)
  );

  assert_prio_order_R11: assert property (@(posedge clk) disable iff (rst)
    ((unb_valid && rsp_valid) |-> !rsp_ready) and ((rsp_valid && mem_valid) |-> !mem_ready));

  assert_wback_dropped_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_ready && mem_kind) |=> $stable(err_o));
endmodule

// File: tb/dir_line_ctrl_tb.sv
module dir_line_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int NC     = 4;
  localparam int SW     = 2;
  localparam int DW     = 16;
  localparam int NPEER  = NC - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_fshr = 0, rsp_valid = 0, rsp_hit = 0;
  logic unb_valid = 0, mem_valid = 0, mem_kind = 0, llc_valid = 0;
  logic [2:0] req_kind = '0;
  logic [SW-1:0] req_src = '0;
  logic [1:0] rsp_kind = '0;
  logic [DW-1:0] rsp_data = '0;
  logic req_ready, rsp_ready, unb_ready, mem_ready, llc_ready;
  logic memrd_o, prb_valid_o, grant_valid_o, memwr_o, err_o;
  logic [1:0] prb_kind_o;
  logic [2:0] grant_kind_o;
  logic [SW-1:0] grant_dst_o;
  logic [DW-1:0] memwr_data_o;

  dir_line_ctrl #(.NUM_CORES(NC), .SRC_W(SW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_src(req_src),
    .req_fshr(req_fshr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data),
    .unb_valid(unb_valid), .unb_ready(unb_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_kind(mem_kind),
    .llc_valid(llc_valid), .llc_ready(llc_ready),
    .memrd_o(memrd_o), .prb_valid_o(prb_valid_o), .prb_kind_o(prb_kind_o),
    .grant_valid_o(grant_valid_o), .grant_kind_o(grant_kind_o), .grant_dst_o(grant_dst_o),
    .memwr_o(memwr_o), .memwr_data_o(memwr_data_o), .err_o(err_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int g_cnt = 0, g_kind = 0, g_dst = 0, rd_cnt = 0, p_cnt = 0, p_kind = 0, w_cnt = 0, w_data = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (grant_valid_o) begin g_cnt++; g_kind = int'(grant_kind_o); g_dst = int'(grant_dst_o); end
      if (memrd_o) rd_cnt++;
      if (prb_valid_o) begin p_cnt++; p_kind = int'(prb_kind_o); end
      if (memwr_o) begin w_cnt++; w_data = int'(memwr_data_o); end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_req(input int k, input int s, input bit f);
    @(negedge clk);
    req_valid = 1; req_kind = 3'(k); req_src = SW'(s); req_fshr = f;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic do_rsp(input int k, input bit h, input int d);
    @(negedge clk);
    rsp_valid = 1; rsp_kind = 2'(k); rsp_hit = h; rsp_data = DW'(d);
    #1;
    while (!rsp_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 rsp_valid = 0;
  endtask

  task automatic do_mem(input bit k);
    @(negedge clk);
    mem_valid = 1; mem_kind = k;
    #1;
    while (!mem_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 mem_valid = 0;
  endtask

  task automatic do_llc();
    @(negedge clk);
    llc_valid = 1;
    #1;
    while (!llc_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 llc_valid = 0;
  endtask

  task automatic do_unb();
    @(negedge clk);
    unb_valid = 1;
    #1;
    while (!unb_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 unb_valid = 0;
  endtask

  function automatic int exp_grant(input int k, input bit hit, input bit f);
    case (k)
      0:       return 0;
      1:       return (hit || f) ? 0 : 1;
      2, 5:    return 2;
      3:       return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_probe(input int k);
    if (k <= 1) return 1;
    if (k == 3) return 3;
    return 2;
  endfunction

  task automatic fill(input bit use_llc);
    if (use_llc) do_llc(); else do_mem(1'b0);
  endtask

  task automatic run_vic(input int k, input int s, input bit stale, input int d);
    int g0, w0;
    g0 = g_cnt; w0 = w_cnt;
    do_req(k, s, 1'b0);
    settle(1);
    check(g_cnt == g0 + 1 && g_kind == 4 && g_dst == s, "R9 victim ack", g_kind, 4);
    if (stale) begin
      do_rsp(2, 1'b0, d);
      settle(2);
      check(w_cnt == w0, "R9 stale writes nothing", w_cnt - w0, 0);
    end else begin
      do_rsp(1, 1'b0, d);
      settle(1);
      check(w_cnt == w0 + 1 && w_data == d, "R9 victim data written", w_data, d);
    end
  endtask

  task automatic run_txn(input int k, input int s, input bit f, input int order, input bit use_llc);
    int g0, r0, p0, eg, extra;
    bit anyhit;
    anyhit = 0;
    g0 = g_cnt; r0 = rd_cnt; p0 = p_cnt;
    do_req(k, s, f);
    settle(1);
    check(p_cnt == p0 + 1 && p_kind == exp_probe(k), "R2 probe kind", p_kind, exp_probe(k));
    check(rd_cnt == r0 + ((k == 3) ? 0 : 1), "R2 memory read launch", rd_cnt - r0, (k == 3) ? 0 : 1);
    extra = 0;
    if (k == 4) begin
      check(g_cnt == g0 + 1 && g_kind == 4 && g_dst == s, "R3 early write ack", g_kind, 4);
      extra = 1;
    end
    // R4: a second request is stalled while busy
    @(negedge clk); req_valid = 1; req_kind = 3'd0; #1;
    check(req_ready == 1'b0, "R4 busy stall", int'(req_ready), 0);
    req_valid = 0;
    for (int i = 0; i < NPEER; i++) begin
      bit h;
      if (k != 3 && ((order == 0 && i == 0) || (order == 2 && i == 1))) fill(use_llc);
      if ($urandom % 3 == 0) do_mem(1'b1);
      h = ($urandom % 4 == 0);
      anyhit |= h;
      do_rsp(0, h, 0);
    end
    if (k != 3 && order == 1) begin
      settle(3);
      check(g_cnt == g0 + extra, "R5 no grant before fill", g_cnt - g0, extra);
      fill(use_llc);
    end
    settle(3);
    eg = exp_grant(k, anyhit, f);
    if (k == 4) begin
      check(g_cnt == g0 + 1, "R8 write-through sends no final grant", g_cnt - g0, 1);
    end else begin
      check(g_cnt == g0 + 1 && g_kind == eg, (k == 3) ? "R7 ctod ack" : "R6 grant kind", g_kind, eg);
      check(g_dst == s, "R6 grant destination", g_dst, s);
      if (k != 5) begin
        @(negedge clk); req_valid = 1; req_kind = 3'd1; #1;
        check(req_ready == 1'b0, "R13 held until unblock", int'(req_ready), 0);
        req_valid = 0;
        do_unb();
      end
    end
    check(err_o == 1'b0, "R10 no error on legal traffic", int'(err_o), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    settle(1);
    check(grant_valid_o == 0 && memrd_o == 0 && prb_valid_o == 0 && memwr_o == 0,
          "R1 reset pulses low", int'(grant_valid_o), 0);
    check(err_o == 0, "R1 reset error clear", int'(err_o), 0);
    check(req_ready == 0, "R1 ready gated by valid", int'(req_ready), 0);

    // Directed: each kind and each fill order
    run_txn(0, 1, 0, 0, 0);
    run_txn(1, 2, 0, 1, 0);
    run_txn(1, 3, 1, 2, 1);
    run_txn(2, 0, 0, 1, 1);
    run_txn(3, 1, 0, 0, 0);
    run_txn(4, 2, 0, 2, 0);
    run_txn(5, 3, 0, 0, 1);
    run_vic(6, 1, 0, 16'hBEEF);
    run_vic(7, 2, 1, 16'h1234);

    // R11: response beats memory in the same cycle
    begin
      int g0;
      g0 = g_cnt;
      do_req(1, 0, 0);
      @(negedge clk);
      rsp_valid = 1; rsp_kind = 2'd0; rsp_hit = 0; mem_valid = 1; mem_kind = 0;
      #1;
      check(rsp_ready == 1 && mem_ready == 0, "R11 response before memory", int'(mem_ready), 0);
      @(posedge clk); #1 rsp_valid = 0;
      while (!mem_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1 mem_valid = 0;
      do_rsp(0, 0, 0);
      do_rsp(0, 0, 0);
      settle(3);
      check(g_cnt == g0 + 1 && g_kind == 1, "R6 plain read exclusive", g_kind, 1);
      do_unb();
    end

    // Random mix
    for (int n = 0; n < 60; n++) begin
      int k;
      k = $urandom % 8;
      if (k >= 6) run_vic(k, $urandom % NC, $urandom % 2, $urandom % 65536);
      else run_txn(k, $urandom % NC, $urandom % 2, $urandom % 3, $urandom % 2);
    end

    // R10: write ack in the idle state
    do_mem(1'b1);
    settle(1);
    check(err_o == 0, "R10 write ack discarded when idle", int'(err_o), 0);

    // R12: illegal messages
    do_unb();
    settle(1);
    check(err_o == 1, "R12 unblock while idle flags error", int'(err_o), 1);
    do_rsp(0, 1, 0);
    settle(2);
    check(err_o == 1, "R12 error sticky", int'(err_o), 1);
    begin
      int p0;
      p0 = p_cnt;
      do_req(0, 2, 0);
      settle(1);
      check(p_cnt == p0 + 1 && p_kind == 1, "R12 state untouched by dropped message", p_kind, 1);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule